// File: doc/BRIEF.md
# Multi-Mode Timer Compare Channel

This block is one compare channel that sits beside a free-running timer. On every clock it compares the timer count with a primary compare value and a secondary compare value. A 3-bit mode field then decides what happens to one output pin: single-shot edges, toggling, bounded pulses, or pulse-width modulation. In the PWM modes the channel also asks the timer to restart at the period value. One PWM variant has an active-low fault input that forces the pin low. When the channel is disabled, the pin follows a general-purpose fallback level.

Software-side writes reach the block as single-cycle strobes with a data value each: mode, primary and secondary. The timer count and its period value are inputs. The block returns the pin level, a one-cycle event pulse and the timer-restart request. Each mode write loads that mode's defined starting pin level on the next clock and re-arms any single-shot behaviour.

Top module: `oc_channel`

## Requirements
- R1: In mode 3'b000 the pin equals `gpio_lvl` in the same cycle, and `irq` stays low.
- R2: In mode 3'b001 the pin starts low. It goes high on the clock edge at which `timer_cnt` equals the primary value, with a one-cycle `irq` in the cycle it rises. It then stays high and does not fire again until the mode is rewritten.
- R3: In mode 3'b010 the pin starts high. It goes low on the edge at which `timer_cnt` equals the primary value, with `irq` on that fall, and it stays low after that.
- R4: In mode 3'b011 the pin keeps its present level on entry. It inverts on every edge at which `timer_cnt` equals the primary value, and `irq` pulses on each change.
- R5: In mode 3'b100 the pin starts low, rises at the primary match, falls at the next secondary match, and does so only once. `irq` pulses on the fall.
- R6: In mode 3'b101 the pin behaves as in R5 but repeats on every timer cycle, with `irq` on each fall.
- R7: Modes 3'b110 and 3'b111 start the pin high when the primary value is non-zero and low otherwise. `tmr_rst` is high in any cycle where `timer_cnt` equals `prd_val` in these modes and low in all other modes. On that edge the secondary value is copied into the primary, and the pin goes high if the copied value is non-zero, else low. The pin goes low on the edge at which `timer_cnt` equals the primary value.
- R8: In mode 3'b110 `irq` never pulses. In mode 3'b111 a low `fault_n` forces the pin low on the next edge, and the pin stays low until the mode is rewritten. `irq` pulses once per falling edge of `fault_n`.
- R9: A mode write (`mode_wr` high) loads the new mode's starting pin level on that edge and clears single-shot completion. It raises no `irq` itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timer_cnt | input | CNT_W | Current count of the external timer |
| prd_val | input | CNT_W | Timer period value used for period match |
| mode_wr | input | 1 | Strobe that loads `mode_in` |
| mode_in | input | 3 | New mode value |
| pri_wr | input | 1 | Strobe that loads `pri_in` |
| pri_in | input | CNT_W | New primary compare value |
| sec_wr | input | 1 | Strobe that loads `sec_in` |
| sec_in | input | CNT_W | New secondary compare value |
| gpio_lvl | input | 1 | Fallback pin level while disabled |
| fault_n | input | 1 | Active-low fault request |
| pin_out | output | 1 | Output pin level |
| irq | output | 1 | One-cycle compare event pulse |
| tmr_rst | output | 1 | Request for the timer to restart |

## Verification
Each mode runs against a timer that repeats 0 to 9 for two and a half periods. The bench counts the high cycles, the event pulses and the final pin level. This separates a one-shot that re-arms from one that holds, a delayed pulse that repeats from one that fires once, and a toggle that counts every match. Two PWM patterns are used: one starts from a zero primary value with a non-zero shadow, the other from a non-zero primary value with a zero shadow. Together they show the copy at the period edge and zero-duty suppression. Directed steps pulse the fault input and check that the pin stays low across a period start. They also rewrite a fired one-shot to show re-arming, and read the restart request in and out of the PWM modes.

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] timer_cnt,
  input  logic [CNT_W-1:0] prd_val,
  input  logic             mode_wr,
  input  logic [2:0]       mode_in,
  input  logic             pri_wr,
  input  logic [CNT_W-1:0] pri_in,
  input  logic             sec_wr,
  input  logic [CNT_W-1:0] sec_in,
  input  logic             gpio_lvl,
  input  logic             fault_n,
  output logic             pin_out,
  output logic             irq,
  output logic             tmr_rst
);

  typedef enum logic [2:0] {
    MD_OFF   = 3'b000,
    MD_OS_HI = 3'b001,
    MD_OS_LO = 3'b010,
    MD_TOG   = 3'b011,
    MD_DLY   = 3'b100,
    MD_PULSE = 3'b101,
    MD_PWM   = 3'b110,
    MD_PWMF  = 3'b111
  } mode_e;

  mode_e            mode_q;
  logic [CNT_W-1:0] pri_q, sec_q, pri_d;
  logic             out_q, out_d;
  logic             done_q, done_d;
  logic             flt_q, flt_d;
  logic             fault_q;
  logic             irq_d;
  logic             init_lvl;

  wire hit_pri = (timer_cnt == pri_q);
  wire hit_sec = (timer_cnt == sec_q);
  wire is_pwm  = (mode_q == MD_PWM) || (mode_q == MD_PWMF);
  wire hit_prd = is_pwm && (timer_cnt == prd_val);
  wire pri_nz  = pri_wr ? (pri_in != '0) : (pri_q != '0);
  wire rise    = out_d & ~out_q;
  wire fall    = ~out_d & out_q;

  assign tmr_rst = hit_prd;
  assign pin_out = (mode_q == MD_OFF) ? gpio_lvl : out_q;

  always_comb begin
    case (mode_e'(mode_in))
      MD_OFF:             init_lvl = gpio_lvl;
      MD_OS_LO:           init_lvl = 1'b1;
      MD_TOG:             init_lvl = out_q;
      MD_PWM, MD_PWMF:    init_lvl = pri_nz;
      default:            init_lvl = 1'b0;
    endcase
  end

  always_comb begin
    out_d  = out_q;
    done_d = done_q;
    flt_d  = flt_q;
    pri_d  = pri_wr ? pri_in : pri_q;
    irq_d  = 1'b0;
    if (mode_wr) begin
      out_d  = init_lvl;
      done_d = 1'b0;
      flt_d  = 1'b0;
    end else begin
      case (mode_q)
        MD_OFF: out_d = gpio_lvl;
        MD_OS_HI: if (!done_q && hit_pri) begin
          out_d  = 1'b1;
          done_d = 1'b1;
        end
        MD_OS_LO: if (!done_q && hit_pri) begin
          out_d  = 1'b0;
          done_d = 1'b1;
        end
        MD_TOG: if (hit_pri) out_d = ~out_q;
        MD_DLY: if (!done_q) begin
          if (out_q && hit_sec) begin
            out_d  = 1'b0;
            done_d = 1'b1;
          end else if (!out_q && hit_pri) begin
            out_d = 1'b1;
          end
        end
        MD_PULSE: begin
          if (out_q && hit_sec)       out_d = 1'b0;
          else if (!out_q && hit_pri) out_d = 1'b1;
        end
        default: begin
          if (hit_prd) begin
            if (!pri_wr) pri_d = sec_q;
            out_d = (sec_q != '0);
          end else if (hit_pri) begin
            out_d = 1'b0;
          end
          if (mode_q == MD_PWMF) begin
            if (!fault_n) flt_d = 1'b1;
            if (flt_d)    out_d = 1'b0;
          end
        end
      endcase
      case (mode_q)
        MD_OS_HI:         irq_d = rise;
        MD_OS_LO:         irq_d = fall;
        MD_TOG:           irq_d = rise | fall;
        MD_DLY, MD_PULSE: irq_d = fall;
        MD_PWMF:          irq_d = fault_q & ~fault_n;
        default:          irq_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_OFF;
      pri_q   <= '0;
      sec_q   <= '0;
      out_q   <= 1'b0;
      done_q  <= 1'b0;
      flt_q   <= 1'b0;
      fault_q <= 1'b1;
      irq     <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= mode_e'(mode_in);
      if (sec_wr)  sec_q  <= sec_in;
      pri_q   <= pri_d;
      out_q   <= out_d;
      done_q  <= done_d;
      flt_q   <= flt_d;
      fault_q <= fault_n;
      irq     <= irq_d;
    end
  end

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_OFF) |-> (!irq && pin_out == gpio_lvl));

  a_r2_oneshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_OS_HI && out_q && !mode_wr) |=> out_q);

  a_r3_oneshot_lo_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_OS_LO && done_q && !mode_wr) |=> !out_q);

  a_r4_event_means_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && mode_q != MD_OFF && !is_pwm) |-> (out_q != $past(out_q)));

  a_r8_pwm_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_PWM) |-> !irq);

  a_r8_fault_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_PWMF && flt_q) |-> !pin_out);

  a_r9_init_lo_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_in == MD_OS_LO) |=> (out_q && !irq));

endmodule

// File: tb/oc_channel_bench.sv
module oc_channel_bench;
  localparam int W = 8;
  localparam logic [W-1:0] PRD = 8'd9;
  localparam int NCYC = 25;

  typedef struct packed {
    logic [2:0]   mode;
    logic [W-1:0] pri;
    logic [W-1:0] sec;
    logic         gpio;
    logic [7:0]   high;
    logic [7:0]   irqs;
    logic         fin;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{3'b000, 8'd0, 8'd0, 1'b1, 8'd25, 8'd0, 1'b1},
    '{3'b001, 8'd3, 8'd0, 1'b0, 8'd22, 8'd1, 1'b1},
    '{3'b010, 8'd3, 8'd0, 1'b0, 8'd3,  8'd1, 1'b0},
    '{3'b011, 8'd3, 8'd0, 1'b0, 8'd12, 8'd3, 1'b1},
    '{3'b100, 8'd3, 8'd7, 1'b0, 8'd4,  8'd1, 1'b0},
    '{3'b101, 8'd3, 8'd7, 1'b0, 8'd10, 8'd2, 1'b1},
    '{3'b110, 8'd0, 8'd4, 1'b0, 8'd10, 8'd0, 1'b0},
    '{3'b110, 8'd5, 8'd0, 1'b0, 8'd5,  8'd0, 1'b0},
    '{3'b111, 8'd2, 8'd2, 1'b0, 8'd8,  8'd0, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic [W-1:0] timer_cnt = '0, pri_in = '0, sec_in = '0;
  logic mode_wr = 0, pri_wr = 0, sec_wr = 0, gpio_lvl = 0, fault_n = 1;
  logic [2:0] mode_in = '0;
  logic pin_out, irq, tmr_rst;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  oc_channel #(.CNT_W(W)) u_oc_channel (
    .clk(clk), .rst_n(rst_n), .timer_cnt(timer_cnt), .prd_val(PRD),
    .mode_wr(mode_wr), .mode_in(mode_in), .pri_wr(pri_wr), .pri_in(pri_in),
    .sec_wr(sec_wr), .sec_in(sec_in), .gpio_lvl(gpio_lvl), .fault_n(fault_n),
    .pin_out(pin_out), .irq(irq), .tmr_rst(tmr_rst)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [2:0] m, input logic [W-1:0] p, input logic [W-1:0] s);
    @(negedge clk);
    mode_in = m; pri_in = p; sec_in = s;
    mode_wr = 1; pri_wr = 1; sec_wr = 1;
    @(negedge clk);
    mode_wr = 0; pri_wr = 0; sec_wr = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pin_out == 0 && irq == 0, "R1 reset pin/irq", pin_out, 0);
    timer_cnt = PRD;
    #1 chk(tmr_rst == 0, "R7 no restart when off", tmr_rst, 0);

    foreach (VECS[i]) begin
      int hi, ev, prev_irq;
      hi = 0; ev = 0;
      gpio_lvl = VECS[i].gpio;
      wr_mode(3'b000, '0, '0);
      mode_in = VECS[i].mode; pri_in = VECS[i].pri; sec_in = VECS[i].sec;
      mode_wr = 1; pri_wr = 1; sec_wr = 1;
      @(negedge clk);
      mode_wr = 0; pri_wr = 0; sec_wr = 0;
      timer_cnt = '0;
      for (int k = 0; k < NCYC; k++) begin
        @(negedge clk);
        if (pin_out) hi++;
        if (irq) ev++;
        timer_cnt = (timer_cnt == PRD) ? '0 : timer_cnt + 1'b1;
      end
      // R1 R2 R3 R4 R5 R6 R7 R8 per mode
      chk(hi == VECS[i].high, $sformatf("R%0d high cycles mode %b", i == 0 ? 1 : (i >= 6 ? 7 : i + 1), VECS[i].mode), hi, VECS[i].high);
      chk(ev == VECS[i].irqs, $sformatf("R8 event count mode %b", VECS[i].mode), ev, VECS[i].irqs);
      chk(pin_out == VECS[i].fin, $sformatf("R9 final pin mode %b", VECS[i].mode), pin_out, VECS[i].fin);
    end

    gpio_lvl = 0; fault_n = 1; timer_cnt = '0;
    wr_mode(3'b111, 8'd3, 8'd3);
    chk(pin_out == 1, "R7 fault-pwm start level", pin_out, 1);
    fault_n = 0;
    @(negedge clk);
    chk(irq == 1 && pin_out == 0, "R8 fault edge event", {irq, pin_out}, 2);
    fault_n = 1;
    timer_cnt = PRD;
    #1 chk(tmr_rst == 1, "R7 restart request at period", tmr_rst, 1);
    @(negedge clk);
    chk(pin_out == 0 && irq == 0, "R8 fault latched over period", {irq, pin_out}, 0);
    timer_cnt = 8'd4;
    #1 chk(tmr_rst == 0, "R7 no restart off period", tmr_rst, 0);
    wr_mode(3'b111, 8'd3, 8'd3);
    chk(pin_out == 1 && irq == 0, "R9 rewrite clears fault", {irq, pin_out}, 1);

    timer_cnt = '0;
    wr_mode(3'b001, 8'd3, 8'd0);
    chk(pin_out == 0, "R2 start low", pin_out, 0);
    timer_cnt = 8'd3;
    @(negedge clk);
    chk(pin_out == 1 && irq == 1, "R2 fires at match", {irq, pin_out}, 3);
    @(negedge clk);
    chk(pin_out == 1 && irq == 0, "R2 no refire", {irq, pin_out}, 1);
    timer_cnt = '0;
    wr_mode(3'b001, 8'd3, 8'd0);
    chk(pin_out == 0 && irq == 0, "R9 rewrite rearms", {irq, pin_out}, 0);
    timer_cnt = 8'd3;
    @(negedge clk);
    chk(pin_out == 1 && irq == 1, "R2 fires after rearm", {irq, pin_out}, 3);

    gpio_lvl = 1;
    wr_mode(3'b011, 8'd7, 8'd0);
    chk(pin_out == 1, "R4 toggle keeps level", pin_out, 1);
    wr_mode(3'b000, 8'd0, 8'd0);
    gpio_lvl = 0;
    #1 chk(pin_out == 0 && irq == 0, "R1 follows fallback", {irq, pin_out}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule